// File: doc/BRIEF.md
# UART Receive Holding and Status Registers

This block is the processor-facing half of a UART receiver. A receive shift register (outside the block) signals a completed character of up to nine bits, with a framing-error indication. The block decides whether that character moves into the readable holding register, and keeps two flags: a ready flag and one shared error flag. Together they encode four states: empty, framing error, normal data, and overrun. In the overrun state the older character is kept.

The processor reads the status register and then the data register. That sequence clears whichever flags the status read saw set. A receiver request is active while either flag is set. It leaves the block only when the receive interrupt enable bit is set. The status register also carries a transmit-empty flag, a transmit interrupt enable and a transmit ninth bit. The transmitter side appears here only as a stimulus input and two outputs.

Top module: `uart_rx_status_regs`

## Requirements
- R1: After reset the status register reads 0x20. Ready, error, both enables and the transmit ninth bit are 0, and transmit-empty is 1. The receiver interrupt output is 0.
- R2: Address 0 is the status register and address 1 is the data register. Status bit 7 is ready, bit 6 is error, bit 5 is transmit-empty, bit 4 is the transmit interrupt enable, bit 3 is the receive interrupt enable, bit 2 is the transmit ninth bit, bit 1 is the received ninth bit and bit 0 reads 0. A write to address 0 changes only bits 4, 3 and 2.
- R3: A character without framing error, arriving with ready=0 and error=0, is copied to the data register, and ready becomes 1 (state 10).
- R4: A character with framing error, arriving with ready=0 and error=0, sets only the error flag (state 01). The data register is unchanged.
- R5: A character arriving with ready=1 and error=0 sets the error flag (state 11) and leaves the data register unchanged.
- R6: While the error flag is 1, an arriving character is not copied and does not set the ready flag.
- R7: A status read that sees a flag at 1, followed by a data read, clears that flag at the data read.
- R8: Any write between the status read and the data read cancels the clear. A data read with no armed status read clears nothing.
- R9: A flag that becomes 1 after the status read is not cleared by the following data read.
- R10: The receiver interrupt output equals (ready OR error) AND the receive interrupt enable. The transmit enable and ninth-bit outputs follow their register bits.
- R11: A data read returns bits 7:0 of the held character. Status bit 1 shows held bit 8 in nine-bit mode and reads 0 in eight-bit mode.
- R12: Status bit 5 shows the transmit-empty input as registered on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe; the read has its side effects at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational; 0 when not reading |
| nine_bit_mode | input | 1 | 1 selects nine-bit characters |
| rx_char_valid | input | 1 | One-cycle pulse when a character completes |
| rx_char_data | input | 9 | Completed character |
| rx_frame_err | input | 1 | The completed character has a framing error |
| tx_empty_in | input | 1 | Transmit buffer empty, from the transmitter model |
| rx_irq | output | 1 | Receiver interrupt request, gated by the enable |
| tx_irq_en | output | 1 | Transmit interrupt enable bit |
| tx_bit8 | output | 1 | Transmit ninth data bit |

## Verification
The in-line assertions check the following on every cycle: each character arrival moves the flags the correct way, and the data register changes only from the empty state. They also check that a falling ready flag is always preceded by an armed data read, and that the interrupt output tracks the flags and the enable. The sequence rules need the bench's scenarios: a write that cancels an armed clear, a data read with no status read, and a flag set between the two reads. The same holds for the four-state decode as seen through register reads and for the nine-bit field visibility. The bench's behavioural model compares the interrupt and transmit outputs on every clock and every register read value.

// File: rtl/uart_rx_pkg.sv
// Package: shared constants for the receive status/data registers.
// Assumes an 8-bit processor bus and characters of at most 9 bits.
package uart_rx_pkg;
    localparam int BUS_W  = 8;
    localparam int CHAR_W = BUS_W + 1;
    // status register bit positions (decoded by software)
    localparam int ST_RDY  = 7;
    localparam int ST_ERR  = 6;
    localparam int ST_TXE  = 5;
    localparam int ST_TIE  = 4;
    localparam int ST_RIE  = 3;
    localparam int ST_TX9  = 2;
    localparam int ST_RX9  = 1;

    typedef struct packed {
        logic rdy;
        logic err;
    } rx_flags_t;
endpackage

// File: rtl/rx_hold_reg.sv
// Module: holding register for the last accepted character.
// Assumes the load strobe comes from the flag controller and is already qualified.
module rx_hold_reg #(
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAR_W-1:0] char_in,
    output logic [CHAR_W-1:0] held
);
    // capture a character when the controller accepts it
    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (load) held <= char_in;
    end

    assert_hold_only_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(held));
endmodule

// File: rtl/rx_flag_ctrl.sv
// Module: ready/error flag state and the read-status-then-read-data clear sequence.
// Assumes at most one bus access per cycle. A write cancels an armed clear.
module rx_flag_ctrl
    import uart_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      char_valid,
    input  logic      frame_err,
    input  logic      stat_rd,
    input  logic      data_rd,
    input  logic      any_wr,
    output rx_flags_t flags,
    output logic      load
);
    rx_flags_t armed;
    logic      set_rdy, set_err, clr_rdy, clr_err;

    // classify the arriving character against the current state
    always_comb begin
        set_rdy = 1'b0;
        set_err = 1'b0;
        if (char_valid && !flags.err) begin
            if (flags.rdy)      set_err = 1'b1;
            else if (frame_err) set_err = 1'b1;
            else                set_rdy = 1'b1;
        end
    end

    assign load    = set_rdy;
    assign clr_rdy = data_rd && !any_wr && armed.rdy;
    assign clr_err = data_rd && !any_wr && armed.err;

    // flag registers: a clear removes old state, a new event always wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags.rdy <= (flags.rdy && !clr_rdy) || set_rdy;
            flags.err <= (flags.err && !clr_err) || set_err;
        end
    end

    // arm on status read, drop on write or on the data read
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= '0;
        else if (any_wr)  armed <= '0;
        else if (stat_rd) armed <= flags;
        else if (data_rd) armed <= '0;
    end

    assert_good_char_sets_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid && !frame_err && !flags.rdy && !flags.err |=> flags.rdy && !flags.err);
    assert_framing_sets_err_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid && frame_err && !flags.rdy && !flags.err |=> !flags.rdy && flags.err);
    assert_overrun_sets_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid && flags.rdy && !flags.err |=> flags.err);
    assert_err_blocks_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid && flags.err |=> !$rose(flags.rdy));
    assert_ready_clear_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags.rdy) |-> $past(data_rd) && $past(armed.rdy));
    assert_write_blocks_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr && flags.rdy |=> flags.rdy);
endmodule

// File: rtl/rx_ctrl_reg.sv
// Module: writable control bits plus the registered transmit-empty flag.
// Assumes wr_stat is already decoded to the status address.
module rx_ctrl_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stat,
    input  logic tie_in,
    input  logic rie_in,
    input  logic tx9_in,
    input  logic tx_empty_in,
    output logic txe,
    output logic tie,
    output logic rie,
    output logic tx9
);
    // software-written enable and ninth-bit fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tie <= 1'b0;
            rie <= 1'b0;
            tx9 <= 1'b0;
        end else if (wr_stat) begin
            tie <= tie_in;
            rie <= rie_in;
            tx9 <= tx9_in;
        end
    end

    // register the transmitter's empty indication
    always_ff @(posedge clk) begin
        if (!rst_n) txe <= 1'b1;
        else        txe <= tx_empty_in;
    end

    assert_txe_tracks_input_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_in |=> txe);
endmodule

// File: rtl/uart_rx_status_regs.sv
// Module: top of the UART receive status/data register block.
// Decodes bus accesses, assembles the status byte and produces the gated
// receiver interrupt. Assumes single-cycle read and write strobes.
module uart_rx_status_regs
    import uart_rx_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 0,
    parameter int DATA_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              nine_bit_mode,
    input  logic              rx_char_valid,
    input  logic [CHAR_W-1:0] rx_char_data,
    input  logic              rx_frame_err,
    input  logic              tx_empty_in,
    output logic              rx_irq,
    output logic              tx_irq_en,
    output logic              tx_bit8
);
    logic              stat_sel, data_sel, stat_rd, data_rd, wr_stat, load;
    logic              txe, tie, rie, tx9;
    logic [CHAR_W-1:0] held;
    logic [BUS_W-1:0]  status;
    rx_flags_t         flags;
    logic              unused_wbits;

    assign stat_sel     = (bus_addr == ADDR_W'(STAT_ADDR));
    assign data_sel     = (bus_addr == ADDR_W'(DATA_ADDR));
    assign stat_rd      = bus_rd && stat_sel;
    assign data_rd      = bus_rd && data_sel;
    assign wr_stat      = bus_wr && stat_sel;
    assign unused_wbits = ^{bus_wdata[BUS_W-1:ST_TIE+1], bus_wdata[ST_RX9:0]};

    rx_flag_ctrl u_flags (
        .clk(clk), .rst_n(rst_n), .char_valid(rx_char_valid), .frame_err(rx_frame_err),
        .stat_rd(stat_rd), .data_rd(data_rd), .any_wr(bus_wr), .flags(flags), .load(load)
    );

    rx_hold_reg #(.CHAR_W(CHAR_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(load), .char_in(rx_char_data), .held(held)
    );

    rx_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat),
        .tie_in(bus_wdata[ST_TIE]), .rie_in(bus_wdata[ST_RIE]), .tx9_in(bus_wdata[ST_TX9]),
        .tx_empty_in(tx_empty_in), .txe(txe), .tie(tie), .rie(rie), .tx9(tx9)
    );

    // assemble the status byte from its fields
    always_comb begin
        status         = '0;
        status[ST_RDY] = flags.rdy;
        status[ST_ERR] = flags.err;
        status[ST_TXE] = txe;
        status[ST_TIE] = tie;
        status[ST_RIE] = rie;
        status[ST_TX9] = tx9;
        status[ST_RX9] = nine_bit_mode && held[CHAR_W-1];
    end

    // read data multiplexer
    always_comb begin
        if (stat_rd)      bus_rdata = status;
        else if (data_rd) bus_rdata = held[BUS_W-1:0];
        else              bus_rdata = '0;
    end

    assign rx_irq    = (flags.rdy || flags.err) && rie;
    assign tx_irq_en = tie;
    assign tx_bit8   = tx9;

    assert_irq_when_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.rdy || flags.err) && rie |-> rx_irq);
    assert_irq_quiet_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !flags.rdy && !flags.err |-> !rx_irq);
    assert_data_changes_from_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(held) |-> $past(!flags.rdy && !flags.err));
endmodule

// File: tb/uart_rx_status_regs_tb.sv
module uart_rx_status_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       nine_bit_mode = 1'b0;
    logic       rx_char_valid = 1'b0;
    logic [8:0] rx_char_data = '0;
    logic       rx_frame_err = 1'b0;
    logic       tx_empty_in = 1'b1;
    logic       rx_irq, tx_irq_en, tx_bit8;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference state
    bit m_rdy, m_err, m_txe, m_tie, m_rie, m_tx9, a_rdy, a_err;
    int m_data;

    uart_rx_status_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nine_bit_mode(nine_bit_mode),
        .rx_char_valid(rx_char_valid), .rx_char_data(rx_char_data), .rx_frame_err(rx_frame_err),
        .tx_empty_in(tx_empty_in), .rx_irq(rx_irq), .tx_irq_en(tx_irq_en), .tx_bit8(tx_bit8)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_status();
        int v;
        v = (int'(m_rdy) << 7) | (int'(m_err) << 6) | (int'(m_txe) << 5) | (int'(m_tie) << 4)
          | (int'(m_rie) << 3) | (int'(m_tx9) << 2);
        if (nine_bit_mode && m_data >= 256) v |= 2;
        return v;
    endfunction

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        bit sr, se, cr, ce, srd, drd;
        cycles++;
        if (!rst_n) begin
            m_rdy = 0; m_err = 0; m_txe = 1; m_tie = 0; m_rie = 0; m_tx9 = 0;
            a_rdy = 0; a_err = 0; m_data = 0;
        end else begin
            srd = bus_rd && bus_addr == 0;
            drd = bus_rd && bus_addr == 1;
            sr = 0; se = 0;
            if (rx_char_valid && !m_err) begin
                if (m_rdy || rx_frame_err) se = 1;
                else begin sr = 1; m_data = int'(rx_char_data); end
            end
            cr = drd && !bus_wr && a_rdy;
            ce = drd && !bus_wr && a_err;
            if (bus_wr)   begin a_rdy = 0; a_err = 0; end
            else if (srd) begin a_rdy = m_rdy; a_err = m_err; end
            else if (drd) begin a_rdy = 0; a_err = 0; end
            m_rdy = (m_rdy && !cr) || sr;
            m_err = (m_err && !ce) || se;
            if (bus_wr && bus_addr == 0) begin
                m_tie = bus_wdata[4]; m_rie = bus_wdata[3]; m_tx9 = bus_wdata[2];
            end
            m_txe = tx_empty_in;
        end
    end

    // compare the always-visible outputs on every clock (R10)
    always @(negedge clk) begin
        if (rst_n) begin
            check("R10 rx_irq", int'(rx_irq), int'((m_rdy || m_err) && m_rie));
            check("R10 tx_irq_en", int'(tx_irq_en), int'(m_tie));
            check("R10 tx_bit8", int'(tx_bit8), int'(m_tx9));
        end
    end

    // drive one cycle of stimulus, then check any read against the model
    task automatic drive(input bit rd, input bit wr, input int addr, input int wd,
                         input bit cv, input bit fe, input int cd, input string req);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = 2'(addr); bus_wdata = 8'(wd);
        rx_char_valid = cv; rx_frame_err = fe; rx_char_data = 9'(cd);
        #(CLK_PERIOD/4);
        if (rd) check(req, int'(bus_rdata), addr == 0 ? model_status() : (m_data & 8'hFF));
    endtask

    task automatic idle(); drive(0, 0, 0, 0, 0, 0, 0, ""); endtask
    task automatic rd(input int addr, input string req); drive(1, 0, addr, 0, 0, 0, 0, req); endtask
    task automatic wr(input int wd); drive(0, 1, 0, wd, 0, 0, 0, ""); endtask
    task automatic rx(input int cd, input bit fe); drive(0, 0, 0, 0, 1, fe, cd, ""); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1: reset values
        rd(0, "R1 reset status");
        check("R1 reset status literal", int'(bus_rdata), 8'h20);
        check("R1 reset irq", int'(rx_irq), 0);
        // R2: only bits 4..2 writable
        wr(8'hFF); idle();
        rd(0, "R2 status after write all-ones");
        check("R2 literal", int'(bus_rdata), 8'h3C);
        wr(8'h08); idle();
        // R3 normal character, then clear via R7 sequence
        rx(9'h0A5, 0); idle();
        rd(0, "R3 ready set"); rd(1, "R11 data low byte"); idle();
        rd(0, "R7 cleared after sequence");
        check("R7 literal", int'(bus_rdata), 8'h28);
        // R4 framing error, data unchanged
        rx(9'h033, 1); idle();
        rd(0, "R4 framing state"); idle();
        drive(1, 0, 1, 0, 0, 0, 0, "R4 data kept");
        // R6 arriving char blocked while error set (state 01)
        rx(9'h055, 0); idle();
        rd(0, "R6 ready stays 0 in framing state");
        rd(1, "R7 clear framing error"); idle();
        rd(0, "R7 error cleared");
        // R5 overrun
        rx(9'h011, 0); rx(9'h022, 0); idle();
        rd(0, "R5 overrun state");
        rx(9'h044, 0); idle();
        rd(1, "R5 R6 first data kept"); idle();
        rd(0, "R7 overrun cleared");
        // R8 write cancels arm
        rx(9'h066, 0); idle();
        rd(0, "R8 arm"); wr(8'h08); rd(1, "R8 data read after write"); idle();
        rd(0, "R8 ready survives");
        // R8 data read alone clears nothing (arm used above? re-clear first)
        rd(1, "R8 data read unarmed"); idle();
        rd(0, "R8 still ready");
        rd(1, "R7 clear"); idle();
        // R9 flag set after status read survives
        rd(0, "R9 arm empty"); rx(9'h077, 0); rd(1, "R9 data read"); idle();
        rd(0, "R9 ready survives");
        rd(1, "R7 clear"); idle();
        // R11 nine-bit visibility
        nine_bit_mode = 1'b1;
        rx(9'h1C3, 0); idle();
        rd(0, "R11 ninth bit shown");
        check("R11 literal", int'(bus_rdata), 8'hAA);
        nine_bit_mode = 1'b0; idle();
        rd(0, "R11 ninth bit hidden in 8-bit mode");
        rd(1, "R11 low byte"); idle();
        // R12 transmit-empty follows input
        tx_empty_in = 1'b0; idle(); idle();
        rd(0, "R12 txe low");
        tx_empty_in = 1'b1; idle(); idle();
        rd(0, "R12 txe high");
        // R10 enable gating
        wr(8'h00); rx(9'h012, 1); idle(); idle();
        wr(8'h08); idle(); idle();
        repeat (3) idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule